// File: doc/BRIEF.md
# Dual Down-Counting Event Timer

This block is a register-mapped timer with two independent 24-bit channels that count down and raise an interrupt when they run out. Software programs an initial count and a control word for each channel. A channel counts once every prescale+1 clocks. In one-shot mode it stops at the end of its count. In periodic mode it reloads the initial count and keeps running.

Each expiry sets a per-channel flag in a shared status word. Software clears a flag by writing 1 to its bit. The interrupt output is raised while any flag is set whose channel has its interrupt enable bit on. Channel 1's live count can be read back, so that channel can also serve as a free-running time base.

The register bus is a single-cycle write strobe with an address and a data word. Read data is combinational from the address. Clearing a channel's enable bit pauses it. Setting the bit again resumes from the held count. When the held count is zero, setting the bit loads the initial count instead.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads zero, except the prescale field of both control words, which reads 1. The interrupt output is low.
- R2: Address map. Control word of channel n at 0x00+4n. Initial count of channel n at 0x08+4n, in bits 23:0. Channel 1 live count at 0x14. Status at 0x18, with flag n in bit n. Any other address reads zero. Control word layout: bit 30 enable, bit 29 interrupt enable, bits 28:27 mode, bits 7:0 prescale, all other bits read zero.
- R3: An enabled channel takes one count step after every prescale+1 clock cycles. A cycle that writes that channel's control word or initial count does not advance its prescaler.
- R4: Loading the initial count:
  - Writing the control word with bit 30 set while the channel is disabled and its count is zero loads the initial count.
  - Writing the initial count while the channel is enabled loads the new value into the counter at once.
  - Either load restarts the prescale phase.
- R5: Pausing and resuming:
  - Writing bit 30 as 0 freezes the count.
  - Writing bit 30 as 1 while the held count is nonzero resumes from the held value without reloading.
- R6: One-shot expiry. In any mode other than 01, the count step that finds the count at 1 or 0 expires the channel, leaves the count at 0 and clears the enable bit.
- R7: Periodic expiry. In mode 01, the expiring step reloads the initial count and the channel stays enabled.
- R8: Every expiry sets that channel's status flag, whatever the interrupt enable bit holds.
- R9: A write to 0x18 clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R10: When an expiry and a clear of the same flag fall in one cycle, the flag ends up set.
- R11: The interrupt output equals the OR over channels of (flag AND interrupt enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are a channel's expiry, which sets its flag, and a software write to the status word, which clears it.

The bench provokes this directly. It loads a one-shot count of 3 with a prescale of 0, so the expiry lands exactly three cycles later. It issues the clearing write in that cycle, then reads the status word and expects the flag still set.

The same overlap also arises many times in the random phase, where writes to the status word hit periodic channels with short counts. Every read there is judged against a cycle-level model of the requirements kept in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH  = 2;
  localparam int EN_BIT  = 30;
  localparam int IE_BIT  = 29;
  localparam int MODE_HI = 28;
  localparam int MODE_LO = 27;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;

  // Strobes from control to the count datapath, one set per channel.
  typedef struct packed {
    logic initWr;    // capture bus data as initial count
    logic loadBus;   // counter takes bus data directly
    logic loadInit;  // counter takes the stored initial count
    logic zero;      // counter forced to zero (one-shot end)
    logic dec;       // counter steps down by one
  } cntStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  cntStrobe_t [NUM_CH-1:0]         st,
  input  logic [CNT_W-1:0]                busVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]    initVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]    cntVal,
  output logic [NUM_CH-1:0]               cntLow,
  output logic [NUM_CH-1:0]               cntZero
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [CNT_W-1:0] initQ;
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        initQ <= '0;
        cntQ  <= '0;
      end else begin
        if (st[g].initWr) initQ <= busVal;
        if (st[g].loadBus)       cntQ <= busVal;
        else if (st[g].loadInit) cntQ <= initQ;
        else if (st[g].zero)     cntQ <= '0;
        else if (st[g].dec)      cntQ <= cntQ - 1'b1;
      end
    end

    assign initVal[g] = initQ;
    assign cntVal[g]  = cntQ;
    assign cntZero[g] = (cntQ == '0);
    assign cntLow[g]  = (cntQ <= CNT_W'(1));
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 24,
  parameter int PSC_W   = 8,
  parameter int PSC_RST = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [31:0]                   busWdata,
  input  logic [NUM_CH-1:0]             cntLow,
  input  logic [NUM_CH-1:0]             cntZero,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  initVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  output cntStrobe_t [NUM_CH-1:0]       st,
  output logic [31:0]                   busRdata,
  output logic [NUM_CH-1:0]             flags,
  output logic [NUM_CH-1:0]             ieBits
);
  localparam int CTRL_BASE = 'h00;
  localparam int INIT_BASE = 'h08;
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'('h18);
  localparam int PAD_W = MODE_LO - PSC_W;

  logic [NUM_CH-1:0]       expire;
  logic [NUM_CH-1:0]       flagsQ;
  logic [NUM_CH-1:0]       clrMask;
  logic [NUM_CH-1:0][31:0] ctrlRd;
  logic                    wrStat;
  logic                    unusedBits;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE + 4 * g);
    localparam logic [ADDR_W-1:0] INIT_A = ADDR_W'(INIT_BASE + 4 * g);

    logic             enQ, ieQ;
    logic [1:0]       modeQ;
    logic [PSC_W-1:0] pscQ, phaseQ;
    logic             wrC, wrI, loadRise, active, tick, periodic;

    assign wrC      = busWr && (busAddr == CTRL_A);
    assign wrI      = busWr && (busAddr == INIT_A);
    assign periodic = (modeQ == MODE_PERIODIC);
    assign loadRise = wrC && busWdata[EN_BIT] && !enQ && cntZero[g];
    assign active   = enQ && !wrC && !wrI;
    assign tick     = active && (phaseQ >= pscQ);
    assign expire[g] = tick && cntLow[g];

    assign st[g] = '{initWr:   wrI,
                     loadBus:  wrI && enQ,
                     loadInit: loadRise || (expire[g] && periodic),
                     zero:     expire[g] && !periodic,
                     dec:      tick && !cntLow[g]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ    <= 1'b0;
        ieQ    <= 1'b0;
        modeQ  <= '0;
        pscQ   <= PSC_W'(PSC_RST);
        phaseQ <= '0;
      end else begin
        if (wrC) begin
          enQ   <= busWdata[EN_BIT];
          ieQ   <= busWdata[IE_BIT];
          modeQ <= busWdata[MODE_HI:MODE_LO];
          pscQ  <= busWdata[PSC_W-1:0];
        end else if (expire[g] && !periodic) begin
          enQ <= 1'b0;
        end
        if (loadRise || (wrI && enQ)) phaseQ <= '0;
        else if (active)              phaseQ <= tick ? '0 : phaseQ + 1'b1;
      end
    end

    assign ctrlRd[g] = {1'b0, enQ, ieQ, modeQ, {PAD_W{1'b0}}, pscQ};
    assign ieBits[g] = ieQ;
  end

  assign wrStat  = busWr && (busAddr == STAT_A);
  assign clrMask = wrStat ? busWdata[NUM_CH-1:0] : '0;

  // Expiry is ORed in after the clear, so a set in the same cycle wins.
  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~clrMask) | expire;
  end
  assign flags = flagsQ;

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(CTRL_BASE + 4 * i)) busRdata = ctrlRd[i];
      if (busAddr == ADDR_W'(INIT_BASE + 4 * i)) busRdata = 32'(initVal[i]);
    end
    if (busAddr == CNT_A)  busRdata = 32'(cntVal[1]);
    if (busAddr == STAT_A) busRdata = 32'(flagsQ);
  end

  assign unusedBits = ^{busWdata[31], busWdata[MODE_LO-1:PSC_W], cntVal[0]};
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 24,
  parameter int PSC_W   = 8,
  parameter int PSC_RST = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);
  cntStrobe_t [NUM_CH-1:0]        strobes;
  logic [NUM_CH-1:0][CNT_W-1:0]   initVal;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntVal;
  logic [NUM_CH-1:0]              cntLow, cntZero, flags, ieBits;

  tmr_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .PSC_RST(PSC_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .cntLow(cntLow), .cntZero(cntZero),
    .initVal(initVal), .cntVal(cntVal), .st(strobes),
    .busRdata(busRdata), .flags(flags), .ieBits(ieBits)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .busVal(busWdata[CNT_W-1:0]),
    .initVal(initVal), .cntVal(cntVal), .cntLow(cntLow), .cntZero(cntZero)
  );

  assign irq = |(flags & ieBits);
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          irq,
  input logic [NUM_CH-1:0]             flags,
  input cntStrobe_t [NUM_CH-1:0]       strobes,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntVal
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes[g].dec |=> cntVal[g] == $past(cntVal[g]) - 1'b1);

    // R6
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes[g].zero |=> (cntVal[g] == '0) && flags[g]);

    // R8
    flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[g]) |-> $past(strobes[g].zero || strobes[g].loadInit));

    // R4
    bus_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes[g].loadBus |-> strobes[g].initWr);

    // R7
    one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobes[g].loadBus, strobes[g].loadInit,
                strobes[g].zero, strobes[g].dec}));

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(strobes[g].loadBus || strobes[g].loadInit || strobes[g].zero ||
        strobes[g].dec) |=> $stable(cntVal[g]));
  end

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != '0));
endmodule

bind dual_down_timer dual_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .flags(flags),
  .strobes(strobes), .cntVal(cntVal)
);

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  // Reference state kept from the requirements.
  bit       mEn[2], mIe[2];
  bit [1:0] mMode[2];
  int       mPsc[2], mPh[2], mInit[2], mCnt[2];
  bit [1:0] mFlag;

  dual_down_timer uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mRead(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      8'h00, 8'h04: begin
        int ch = (a == 8'h04) ? 1 : 0;
        r[30] = mEn[ch]; r[29] = mIe[ch]; r[28:27] = mMode[ch];
        r[7:0] = mPsc[ch][7:0];
      end
      8'h08: r = 32'(mInit[0]);
      8'h0C: r = 32'(mInit[1]);
      8'h14: r = 32'(mCnt[1]);
      8'h18: r = 32'(mFlag);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic mIrq();
    return (mFlag[0] & mIe[0]) | (mFlag[1] & mIe[1]);
  endfunction

  task automatic mAdvance(input logic wr, input logic [7:0] a, input logic [31:0] d);
    bit [1:0] ex = '0;
    for (int ch = 0; ch < 2; ch++) begin
      bit wc = wr && (a == 8'(4 * ch));
      bit wi = wr && (a == 8'(8 + 4 * ch));
      if (wc) begin
        if (d[30] && !mEn[ch] && mCnt[ch] == 0) begin
          mCnt[ch] = mInit[ch]; mPh[ch] = 0;
        end
        mEn[ch] = d[30]; mIe[ch] = d[29]; mMode[ch] = d[28:27];
        mPsc[ch] = int'(d[7:0]);
      end else if (wi) begin
        mInit[ch] = int'(d[23:0]);
        if (mEn[ch]) begin mCnt[ch] = mInit[ch]; mPh[ch] = 0; end
      end else if (mEn[ch]) begin
        if (mPh[ch] >= mPsc[ch]) begin
          mPh[ch] = 0;
          if (mCnt[ch] <= 1) begin
            ex[ch] = 1'b1;
            if (mMode[ch] == 2'b01) mCnt[ch] = mInit[ch];
            else begin mCnt[ch] = 0; mEn[ch] = 1'b0; end
          end else mCnt[ch] = mCnt[ch] - 1;
        end else mPh[ch] = mPh[ch] + 1;
      end
    end
    if (wr && a == 8'h18) mFlag = mFlag & ~d[1:0];
    mFlag = mFlag | ex;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input string tag);
    @(negedge clk);
    busWr = wr; busAddr = a; busWdata = d;
    #1;
    if (!wr) chk(busRdata, mRead(a), tag, "read");
    chk(32'(irq), 32'(mIrq()), "R11", "irq");
    mAdvance(wr, a, d);
  endtask

  task automatic peek(input logic [7:0] a, input logic [31:0] lit, input string tag);
    @(negedge clk);
    busWr = 1'b0; busAddr = a; busWdata = '0;
    #1;
    chk(busRdata, lit, tag, "directed read");
    chk(busRdata, mRead(a), tag, "model read");
    chk(32'(irq), 32'(mIrq()), "R11", "irq");
    mAdvance(1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs[8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h10, 8'h1C};
    void'($urandom(32'd2024));
    for (int ch = 0; ch < 2; ch++) begin
      mEn[ch] = 0; mIe[ch] = 0; mMode[ch] = 0; mPsc[ch] = 1;
      mPh[ch] = 0; mInit[ch] = 0; mCnt[ch] = 0;
    end
    mFlag = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mAdvance(1'b0, 8'h00, 32'd0);

    // R1 / R2: reset values and unmapped addresses
    peek(8'h00, 32'h1, "R1");
    peek(8'h04, 32'h1, "R1");
    peek(8'h08, 32'h0, "R1");
    peek(8'h0C, 32'h0, "R1");
    peek(8'h14, 32'h0, "R1");
    peek(8'h18, 32'h0, "R1");
    peek(8'h10, 32'h0, "R2");
    peek(8'h1C, 32'h0, "R2");
    chk(32'(irq), 32'h0, "R1", "irq after reset");

    // One-shot on channel 1, prescale 0
    cyc(1'b1, 8'h0C, 32'd5, "R4");
    cyc(1'b1, 8'h04, 32'h6000_0000, "R4");
    for (int k = 5; k >= 0; k--) peek(8'h14, 32'(k), "R6");
    peek(8'h04, 32'h2000_0000, "R6");
    peek(8'h18, 32'h2, "R8");
    chk(32'(irq), 32'h1, "R11", "irq enabled flag");
    cyc(1'b1, 8'h18, 32'h1, "R9");
    peek(8'h18, 32'h2, "R9");
    cyc(1'b1, 8'h18, 32'h2, "R9");
    peek(8'h18, 32'h0, "R9");
    chk(32'(irq), 32'h0, "R11", "irq after clear");

    // Periodic on channel 0, prescale 2, interrupt disabled
    cyc(1'b1, 8'h08, 32'd3, "R4");
    cyc(1'b1, 8'h00, 32'h4800_0002, "R7");
    for (int k = 0; k < 8; k++) cyc(1'b0, 8'h18, 32'd0, "R3");
    peek(8'h18, 32'h0, "R3");
    peek(8'h18, 32'h1, "R8");
    chk(32'(irq), 32'h0, "R11", "irq masked");
    peek(8'h00, 32'h4800_0002, "R7");
    cyc(1'b1, 8'h00, 32'h0000_0002, "R5");
    cyc(1'b1, 8'h18, 32'h3, "R9");

    // Pause and resume on channel 1
    cyc(1'b1, 8'h0C, 32'd10, "R4");
    cyc(1'b1, 8'h04, 32'h4800_0000, "R4");
    peek(8'h14, 32'd10, "R4");
    peek(8'h14, 32'd9, "R3");
    peek(8'h14, 32'd8, "R3");
    cyc(1'b1, 8'h04, 32'h0800_0000, "R5");
    for (int k = 0; k < 3; k++) peek(8'h14, 32'd7, "R5");
    cyc(1'b1, 8'h04, 32'h4800_0000, "R5");
    peek(8'h14, 32'd7, "R5");
    peek(8'h14, 32'd6, "R5");
    cyc(1'b1, 8'h0C, 32'd20, "R4");
    peek(8'h14, 32'd20, "R4");
    peek(8'h14, 32'd19, "R4");
    cyc(1'b1, 8'h0C, 32'd2, "R4");
    peek(8'h14, 32'd2, "R7");
    peek(8'h14, 32'd1, "R7");
    peek(8'h14, 32'd2, "R7");
    peek(8'h18, 32'h2, "R8");
    peek(8'h14, 32'd2, "R7");
    cyc(1'b1, 8'h04, 32'h0, "R5");
    cyc(1'b1, 8'h18, 32'h3, "R9");
    peek(8'h18, 32'h0, "R9");

    // Expiry and clear in the same cycle: set must win
    cyc(1'b1, 8'h04, 32'h4000_0000, "R5");
    cyc(1'b1, 8'h0C, 32'd3, "R4");
    peek(8'h14, 32'd3, "R10");
    peek(8'h14, 32'd2, "R10");
    cyc(1'b1, 8'h18, 32'h2, "R10");
    peek(8'h18, 32'h2, "R10");
    peek(8'h14, 32'd0, "R6");
    peek(8'h04, 32'h0, "R6");

    // Constrained random traffic checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a = addrs[$urandom_range(0, 7)];
      logic        wr = ($urandom_range(0, 9) < 3);
      logic [31:0] d = $urandom;
      if (a == 8'h00 || a == 8'h04) begin
        d[30] = ($urandom_range(0, 3) != 0);
        d[7:0] = 8'($urandom_range(0, 3));
      end else if (a == 8'h08 || a == 8'h0C) begin
        d = ($urandom_range(0, 49) == 0) ? 32'h00FF_FFFF : 32'($urandom_range(0, 12));
      end else if (a == 8'h18) begin
        d = 32'($urandom_range(0, 3));
      end
      cyc(wr, a, d, "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule